// File: doc/BRIEF.md
# MESI Snooping Coherence Controller

This block keeps one small direct-mapped write-back cache coherent with its peers on a shared snooping bus. Each line holds one data word, a tag and one of four coherence states: Modified (dirty, only copy), Exclusive (clean, only copy), Shared (clean, other copies may exist) and Invalid. The processor issues reads and writes. The controller answers hits locally and turns misses, upgrades and dirty evictions into bus transactions. The line index is the low `log2(LINES)` address bits and the tag is the remaining upper bits.

Reads, writes and write-backs that other caches place on the bus come in through the snoop port. For each one the controller updates the addressed line in the same clock. In that same cycle it can drive the wired-OR shared line and supply dirty data (a flush). The controller's own read fills sample the shared line. A fill lands in Exclusive when no peer holds the block, so a later write to that line needs no bus traffic.

The processor-side machine has the states IDLE, EVICT, FETCH and DONE. IDLE → DONE covers a read hit and a write hit in Exclusive or Modified. IDLE → EVICT covers a miss whose victim is Modified. IDLE → FETCH covers a miss with a clean or invalid victim, or a write hit in Shared. EVICT → FETCH happens when the write-back is acknowledged. FETCH → DONE happens when the fill arrives. DONE → IDLE always follows one cycle later.

Top module: `mesi_coherence_ctrl`

## Requirements
- R1: After reset every line is Invalid. `cpu_done`, `bus_req_valid`, `snp_shared` and `snp_flush` are low, and a snoop to any address finds no copy.
- R2: A processor read that misses issues a bus read (`bus_req_cmd` = 0). The line fills as Exclusive if `bus_shared_in` is low with the response, and as Shared if it is high. The returned word appears on `cpu_rdata`.
- R3: A processor write to a line in Exclusive or Modified completes with no bus transaction and leaves the line Modified.
- R4: A processor write to a line in Shared or Invalid issues a read-for-ownership (`bus_req_cmd` = 1) and leaves the line Modified with the written word.
- R5: A snooped read (`snp_cmd` = 0) that hits a valid line raises `snp_shared` in the same cycle. A hit in Exclusive or Shared leaves the line Shared.
- R6: A snooped read that hits a Modified line raises `snp_flush` in the same cycle, drives the line's word on `snp_flush_data`, and leaves the line Shared.
- R7: A snooped read-for-ownership (`snp_cmd` = 1) that hits invalidates the line, flushes first if the line is Modified, and never raises `snp_shared`.
- R8: Only a Modified line supplies data, so clean copies never flush. A snoop that misses, because of a tag mismatch or an Invalid line, changes nothing.
- R9: A miss whose victim is Modified first writes the victim back (`bus_req_cmd` = 2, with the victim's address and word) and only then fetches the new block. A clean victim is dropped with no write-back.
- R10: When a snoop and a processor request target the same index in the same cycle, the snoop is applied first and the processor request is taken afterwards against the updated line.
- R11: `bus_req_valid` stays high with a stable command and address until `bus_resp_valid`. `cpu_done` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Processor address |
| cpu_wdata | input | DATA_W | Processor write word |
| cpu_done | output | 1 | Request completed (one-cycle pulse) |
| cpu_rdata | output | DATA_W | Read result |
| bus_req_valid | output | 1 | Own bus transaction pending |
| bus_req_cmd | output | 2 | 0 read, 1 read-for-ownership, 2 write-back |
| bus_req_addr | output | ADDR_W | Transaction address |
| bus_req_data | output | DATA_W | Write-back word |
| bus_resp_valid | input | 1 | Memory response / acknowledge |
| bus_resp_data | input | DATA_W | Fill word |
| bus_shared_in | input | 1 | Wired-OR shared line, sampled with the response |
| snp_valid | input | 1 | Peer transaction on the bus |
| snp_cmd | input | 2 | 0 read, 1 read-for-ownership |
| snp_addr | input | ADDR_W | Peer transaction address |
| snp_shared | output | 1 | This cache's contribution to the shared line |
| snp_flush | output | 1 | This cache supplies dirty data |
| snp_flush_data | output | DATA_W | Supplied word |

## Verification
The main function is exercised by a sequence of processor reads and writes. They walk each line through every state, using an unshared fill, a shared fill, a hit in each state, and evictions of both dirty and clean victims. Counting bus reads, ownership reads and write-backs per operation separates Exclusive from Shared, because only Shared needs a bus transaction before a write. Those counts also show whether a victim was dirty. Directed snoops then hit lines in Modified, Exclusive and Shared, miss on a tag mismatch, and collide with a processor request on the same index. Each follow-up processor access shows whether the line was demoted, invalidated or left alone.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

    typedef enum logic [1:0] {
        LS_I = 2'd0,
        LS_S = 2'd1,
        LS_E = 2'd2,
        LS_M = 2'd3
    } line_state_e;

    typedef enum logic [1:0] {
        BC_RD   = 2'd0,
        BC_RDX  = 2'd1,
        BC_WB   = 2'd2,
        BC_NONE = 2'd3
    } bus_cmd_e;

    typedef enum logic [1:0] {
        CS_IDLE  = 2'd0,
        CS_EVICT = 2'd1,
        CS_FETCH = 2'd2,
        CS_DONE  = 2'd3
    } ctrl_state_e;

endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
    import mesi_pkg::*;
#(
    parameter int LINES  = 4,
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  a_idx,
    output line_state_e       a_state,
    output logic [TAG_W-1:0]  a_tag,
    output logic [DATA_W-1:0] a_data,
    input  logic [IDX_W-1:0]  b_idx,
    output line_state_e       b_state,
    output logic [TAG_W-1:0]  b_tag,
    output logic [DATA_W-1:0] b_data,
    input  logic              cw_en,
    input  logic [IDX_W-1:0]  cw_idx,
    input  line_state_e       cw_state,
    input  logic [TAG_W-1:0]  cw_tag,
    input  logic [DATA_W-1:0] cw_data,
    input  logic              sw_en,
    input  logic [IDX_W-1:0]  sw_idx,
    input  line_state_e       sw_state
);

    logic [LINES*2-1:0]      st_flat;
    logic [LINES*TAG_W-1:0]  tag_flat;
    logic [LINES*DATA_W-1:0] dat_flat;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        line_state_e       st_r;
        logic [TAG_W-1:0]  tag_r;
        logic [DATA_W-1:0] dat_r;
        logic              snp_sel;
        logic              cpu_sel;

        assign snp_sel = sw_en && (sw_idx == IDX_W'(g));
        assign cpu_sel = cw_en && (cw_idx == IDX_W'(g));

        // snoop update wins over a processor update to the same line
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_r  <= LS_I;
                tag_r <= '0;
                dat_r <= '0;
            end else if (snp_sel) begin
                st_r <= sw_state;
            end else if (cpu_sel) begin
                st_r  <= cw_state;
                tag_r <= cw_tag;
                dat_r <= cw_data;
            end
        end

        assign st_flat[g*2 +: 2]           = st_r;
        assign tag_flat[g*TAG_W +: TAG_W]  = tag_r;
        assign dat_flat[g*DATA_W +: DATA_W] = dat_r;
    end

    assign a_state = line_state_e'(st_flat[a_idx*2 +: 2]);
    assign a_tag   = tag_flat[a_idx*TAG_W +: TAG_W];
    assign a_data  = dat_flat[a_idx*DATA_W +: DATA_W];
    assign b_state = line_state_e'(st_flat[b_idx*2 +: 2]);
    assign b_tag   = tag_flat[b_idx*TAG_W +: TAG_W];
    assign b_data  = dat_flat[b_idx*DATA_W +: DATA_W];

endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
    import mesi_pkg::*;
#(
    parameter int TAG_W = 6
) (
    input  logic             snp_valid,
    input  bus_cmd_e         snp_cmd,
    input  logic [TAG_W-1:0] snp_tag,
    input  line_state_e      line_state,
    input  logic [TAG_W-1:0] line_tag,
    output logic             shared_o,
    output logic             flush_o,
    output logic             upd_en,
    output line_state_e      upd_state
);

    logic hit;

    assign hit = snp_valid && (line_state != LS_I) && (line_tag == snp_tag);

    always_comb begin
        shared_o  = 1'b0;
        flush_o   = 1'b0;
        upd_en    = 1'b0;
        upd_state = line_state;
        if (hit) begin
            unique case (snp_cmd)
                BC_RD: begin
                    shared_o  = 1'b1;
                    flush_o   = (line_state == LS_M);
                    upd_en    = 1'b1;
                    upd_state = LS_S;
                end
                BC_RDX: begin
                    flush_o   = (line_state == LS_M);
                    upd_en    = 1'b1;
                    upd_state = LS_I;
                end
                default: begin
                    upd_en = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/mesi_cpu_fsm.sv
module mesi_cpu_fsm
    import mesi_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              snoop_block,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic [IDX_W-1:0]  look_idx,
    input  line_state_e       line_state,
    input  logic [TAG_W-1:0]  line_tag,
    input  logic [DATA_W-1:0] line_data,
    output logic              cw_en,
    output line_state_e       cw_state,
    output logic [TAG_W-1:0]  cw_tag,
    output logic [DATA_W-1:0] cw_data,
    output logic              bus_req_valid,
    output bus_cmd_e          bus_req_cmd,
    output logic [ADDR_W-1:0] bus_req_addr,
    output logic [DATA_W-1:0] bus_req_data,
    input  logic              bus_resp_valid,
    input  logic [DATA_W-1:0] bus_resp_data,
    input  logic              bus_shared_in
);

    ctrl_state_e       st_q, st_d;
    logic [IDX_W-1:0]  idx_q;
    logic [TAG_W-1:0]  tag_q;
    logic              we_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    bus_cmd_e          fcmd_q;

    logic [IDX_W-1:0]  cur_idx;
    logic [TAG_W-1:0]  cur_tag;
    logic              accept;
    logic              hit;

    assign cur_idx  = cpu_addr[IDX_W-1:0];
    assign cur_tag  = cpu_addr[ADDR_W-1:IDX_W];
    assign look_idx = (st_q == CS_IDLE) ? cur_idx : idx_q;
    assign accept   = cpu_req && !snoop_block && (st_q == CS_IDLE);
    assign hit      = (line_state != LS_I) && (line_tag == cur_tag);

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= CS_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d     = st_q;
        cw_en    = 1'b0;
        cw_state = line_state;
        cw_tag   = line_tag;
        cw_data  = line_data;
        unique case (st_q)
            CS_IDLE: begin
                if (accept) begin
                    if (hit && !cpu_we) begin
                        st_d = CS_DONE;
                    end else if (hit && line_state != LS_S) begin
                        cw_en    = 1'b1;
                        cw_state = LS_M;
                        cw_data  = cpu_wdata;
                        st_d     = CS_DONE;
                    end else if (!hit && line_state == LS_M) begin
                        st_d = CS_EVICT;
                    end else begin
                        st_d = CS_FETCH;
                    end
                end
            end
            CS_EVICT: begin
                if (bus_resp_valid) begin
                    cw_en    = 1'b1;
                    cw_state = LS_I;
                    st_d     = CS_FETCH;
                end
            end
            CS_FETCH: begin
                if (bus_resp_valid) begin
                    cw_en  = 1'b1;
                    cw_tag = tag_q;
                    if (fcmd_q == BC_RDX) cw_state = LS_M;
                    else if (bus_shared_in) cw_state = LS_S;
                    else cw_state = LS_E;
                    cw_data = we_q ? wdata_q : bus_resp_data;
                    st_d    = CS_DONE;
                end
            end
            CS_DONE: st_d = CS_IDLE;
            default: st_d = CS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q   <= '0;
            tag_q   <= '0;
            we_q    <= 1'b0;
            wdata_q <= '0;
            rdata_q <= '0;
            fcmd_q  <= BC_RD;
        end else begin
            if (accept) begin
                idx_q   <= cur_idx;
                tag_q   <= cur_tag;
                we_q    <= cpu_we;
                wdata_q <= cpu_wdata;
                fcmd_q  <= cpu_we ? BC_RDX : BC_RD;
                if (hit && !cpu_we) rdata_q <= line_data;
            end
            if (st_q == CS_FETCH && bus_resp_valid && !we_q) rdata_q <= bus_resp_data;
        end
    end

    always_comb begin
        bus_req_valid = 1'b0;
        bus_req_cmd   = BC_NONE;
        bus_req_addr  = {tag_q, idx_q};
        bus_req_data  = '0;
        unique case (st_q)
            CS_EVICT: begin
                bus_req_valid = 1'b1;
                bus_req_cmd   = BC_WB;
                bus_req_addr  = {line_tag, idx_q};
                bus_req_data  = line_data;
            end
            CS_FETCH: begin
                bus_req_valid = 1'b1;
                bus_req_cmd   = fcmd_q;
            end
            default: bus_req_valid = 1'b0;
        endcase
    end

    assign cpu_done  = (st_q == CS_DONE);
    assign cpu_rdata = rdata_q;

endmodule

// File: rtl/mesi_coherence_ctrl.sv
module mesi_coherence_ctrl
    import mesi_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int LINES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req_valid,
    output logic [1:0]        bus_req_cmd,
    output logic [ADDR_W-1:0] bus_req_addr,
    output logic [DATA_W-1:0] bus_req_data,
    input  logic              bus_resp_valid,
    input  logic [DATA_W-1:0] bus_resp_data,
    input  logic              bus_shared_in,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_shared,
    output logic              snp_flush,
    output logic [DATA_W-1:0] snp_flush_data
);

    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0]  look_idx;
    line_state_e       a_state, b_state, cw_state, sw_state;
    logic [TAG_W-1:0]  a_tag, b_tag, cw_tag;
    logic [DATA_W-1:0] a_data, b_data, cw_data;
    logic              cw_en, sw_en;
    logic [IDX_W-1:0]  snp_idx;
    logic              snoop_block;
    bus_cmd_e          req_cmd;

    assign snp_idx     = snp_addr[IDX_W-1:0];
    assign snoop_block = snp_valid && (snp_idx == cpu_addr[IDX_W-1:0]);

    mesi_line_store #(
        .LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .a_idx(look_idx), .a_state(a_state), .a_tag(a_tag), .a_data(a_data),
        .b_idx(snp_idx), .b_state(b_state), .b_tag(b_tag), .b_data(b_data),
        .cw_en(cw_en), .cw_idx(look_idx), .cw_state(cw_state), .cw_tag(cw_tag), .cw_data(cw_data),
        .sw_en(sw_en), .sw_idx(snp_idx), .sw_state(sw_state)
    );

    mesi_snoop_unit #(.TAG_W(TAG_W)) u_snoop (
        .snp_valid(snp_valid),
        .snp_cmd(bus_cmd_e'(snp_cmd)),
        .snp_tag(snp_addr[ADDR_W-1:IDX_W]),
        .line_state(b_state),
        .line_tag(b_tag),
        .shared_o(snp_shared),
        .flush_o(snp_flush),
        .upd_en(sw_en),
        .upd_state(sw_state)
    );

    mesi_cpu_fsm #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .TAG_W(TAG_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .snoop_block(snoop_block),
        .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
        .look_idx(look_idx),
        .line_state(a_state), .line_tag(a_tag), .line_data(a_data),
        .cw_en(cw_en), .cw_state(cw_state), .cw_tag(cw_tag), .cw_data(cw_data),
        .bus_req_valid(bus_req_valid), .bus_req_cmd(req_cmd),
        .bus_req_addr(bus_req_addr), .bus_req_data(bus_req_data),
        .bus_resp_valid(bus_resp_valid), .bus_resp_data(bus_resp_data),
        .bus_shared_in(bus_shared_in)
    );

    assign bus_req_cmd    = req_cmd;
    assign snp_flush_data = b_data;

endmodule

// File: rtl/mesi_coherence_chk.sv
module mesi_coherence_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_done,
    input logic              bus_req_valid,
    input logic [1:0]        bus_req_cmd,
    input logic [ADDR_W-1:0] bus_req_addr,
    input logic              bus_resp_valid,
    input logic              snp_valid,
    input logic [1:0]        snp_cmd,
    input logic              snp_shared,
    input logic              snp_flush
);

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_valid && !bus_resp_valid |=> bus_req_valid && $stable(bus_req_cmd) && $stable(bus_req_addr));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done);

    // R9
    wb_then_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_valid && bus_resp_valid && bus_req_cmd == 2'd2 |=> bus_req_valid && bus_req_cmd != 2'd2);

    // R7
    rdx_no_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid && snp_cmd == 2'd1 |-> !snp_shared);

    // R5
    shared_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snp_shared |-> snp_valid && snp_cmd == 2'd0);

    // R8
    flush_needs_snoop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snp_flush |-> snp_valid);

    // R1
    idle_after_reset_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> !cpu_done && !bus_req_valid);

endmodule

bind mesi_coherence_ctrl mesi_coherence_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_done(cpu_done),
    .bus_req_valid(bus_req_valid), .bus_req_cmd(bus_req_cmd), .bus_req_addr(bus_req_addr),
    .bus_resp_valid(bus_resp_valid), .snp_valid(snp_valid), .snp_cmd(snp_cmd),
    .snp_shared(snp_shared), .snp_flush(snp_flush)
);

// File: tb/test_mesi_coherence_ctrl.sv
module test_mesi_coherence_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_req = 1'b0, cpu_we = 1'b0;
    logic [7:0] cpu_addr = '0, cpu_wdata = '0;
    logic       cpu_done;
    logic [7:0] cpu_rdata;
    logic       bus_req_valid;
    logic [1:0] bus_req_cmd;
    logic [7:0] bus_req_addr, bus_req_data;
    logic       bus_resp_valid = 1'b0;
    logic [7:0] bus_resp_data = '0;
    logic       shared_cfg = 1'b0;
    logic       snp_valid = 1'b0;
    logic [1:0] snp_cmd = '0;
    logic [7:0] snp_addr = '0;
    logic       snp_shared, snp_flush;
    logic [7:0] snp_flush_data;

    int n_chk = 0, n_fail = 0;
    int n_rd = 0, n_rdx = 0, n_wb = 0;
    int wait_cnt = 0;
    logic [7:0] mem [256];
    logic [7:0] rd_val;

    always #5 clk = ~clk;

    mesi_coherence_ctrl i_mesi_coherence_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
        .bus_req_valid(bus_req_valid), .bus_req_cmd(bus_req_cmd),
        .bus_req_addr(bus_req_addr), .bus_req_data(bus_req_data),
        .bus_resp_valid(bus_resp_valid), .bus_resp_data(bus_resp_data),
        .bus_shared_in(shared_cfg),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
        .snp_shared(snp_shared), .snp_flush(snp_flush), .snp_flush_data(snp_flush_data)
    );

    // behavioural memory: answers three cycles after a request appears
    always @(negedge clk) begin
        if (bus_resp_valid) begin
            bus_resp_valid = 1'b0;
            wait_cnt = 0;
        end else if (bus_req_valid) begin
            if (wait_cnt == 2) begin
                bus_resp_valid = 1'b1;
                bus_resp_data  = mem[bus_req_addr];
                case (bus_req_cmd)
                    2'd0: n_rd++;
                    2'd1: n_rdx++;
                    2'd2: begin n_wb++; mem[bus_req_addr] = bus_req_data; end
                    default: ;
                endcase
            end else begin
                wait_cnt++;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic we, input logic [7:0] a, input logic [7:0] wd,
                          input logic shr, output logic [7:0] rd);
        n_rd = 0; n_rdx = 0; n_wb = 0;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd; shared_cfg = shr;
        @(negedge clk);
        while (!cpu_done) @(negedge clk);
        rd = cpu_rdata;
        cpu_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic snoop(input string req, input logic [1:0] c, input logic [7:0] a,
                         input logic esh, input logic efl, input logic [7:0] edat);
        snp_valid = 1'b1; snp_cmd = c; snp_addr = a;
        #2;
        chk({req, " shared"}, snp_shared, esh);
        chk({req, " flush"}, snp_flush, efl);
        if (efl) begin
            chk({req, " flush data"}, snp_flush_data, edat);
            mem[a] = snp_flush_data;
        end
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    task automatic counts(input string req, input int er, input int ex, input int ew);
        chk({req, " bus reads"}, n_rd, er);
        chk({req, " ownership reads"}, n_rdx, ex);
        chk({req, " write-backs"}, n_wb, ew);
    endtask

    typedef struct packed {
        logic       we;
        logic [7:0] addr;
        logic [7:0] wdata;
        logic       shr;
        logic [7:0] exp;
        logic [1:0] nrd;
        logic [1:0] nrdx;
        logic [1:0] nwb;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 8'h10, 8'h00, 1'b0, 8'h4A, 2'd1, 2'd0, 2'd0}, // R2 miss, not shared -> E
        '{1'b1, 8'h10, 8'hA1, 1'b0, 8'h00, 2'd0, 2'd0, 2'd0}, // R3 E -> M silently
        '{1'b0, 8'h10, 8'h00, 1'b0, 8'hA1, 2'd0, 2'd0, 2'd0}, // R3 hit in M
        '{1'b0, 8'h21, 8'h00, 1'b1, 8'h7B, 2'd1, 2'd0, 2'd0}, // R2 miss, shared -> S
        '{1'b1, 8'h21, 8'hB2, 1'b0, 8'h00, 2'd0, 2'd1, 2'd0}, // R4 S upgrade
        '{1'b0, 8'h21, 8'h00, 1'b0, 8'hB2, 2'd0, 2'd0, 2'd0}, // R4 data kept
        '{1'b0, 8'h14, 8'h00, 1'b0, 8'h4E, 2'd1, 2'd0, 2'd1}, // R9 dirty victim
        '{1'b0, 8'h10, 8'h00, 1'b0, 8'hA1, 2'd1, 2'd0, 2'd0}, // R9 clean victim, wb data
        '{1'b1, 8'h32, 8'hC3, 1'b0, 8'h00, 2'd0, 2'd1, 2'd0}, // R4 write miss on I
        '{1'b1, 8'h32, 8'hC4, 1'b0, 8'h00, 2'd0, 2'd0, 2'd0}, // R3 write hit in M
        '{1'b0, 8'h32, 8'h00, 1'b0, 8'hC4, 2'd0, 2'd0, 2'd0}, // R3 data
        '{1'b1, 8'h36, 8'hD5, 1'b0, 8'h00, 2'd0, 2'd1, 2'd1}, // R9 dirty victim on write
        '{1'b0, 8'h32, 8'h00, 1'b1, 8'hC4, 2'd1, 2'd0, 2'd1}, // R9 write-back then read
        '{1'b0, 8'h36, 8'h00, 1'b0, 8'hD5, 2'd1, 2'd0, 2'd0}  // R9 S victim dropped
    };

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 cpu_done", cpu_done, 0);
        chk("R1 bus_req_valid", bus_req_valid, 0);
        chk("R1 snp_shared", snp_shared, 0);
        chk("R1 snp_flush", snp_flush, 0);
        snoop("R1 snoop after reset", 2'd0, 8'h10, 1'b0, 1'b0, 8'h00);

        for (int v = 0; v < NV; v++) begin
            run_op(VEC[v].we, VEC[v].addr, VEC[v].wdata, VEC[v].shr, rd_val);
            counts($sformatf("vector %0d (R2 R3 R4 R9)", v), VEC[v].nrd, VEC[v].nrdx, VEC[v].nwb);
            if (!VEC[v].we) chk($sformatf("vector %0d read data (R2)", v), rd_val, VEC[v].exp);
        end

        // R6 snooped read to M flushes and demotes to S
        snoop("R6 read on M", 2'd0, 8'h21, 1'b1, 1'b1, 8'hB2);
        run_op(1'b1, 8'h21, 8'hE1, 1'b0, rd_val);
        counts("R6 line left Shared", 0, 1, 0);

        // R5 snooped read on E: shared, no flush, demoted to S
        snoop("R5 read on E", 2'd0, 8'h10, 1'b1, 1'b0, 8'h00);
        run_op(1'b1, 8'h10, 8'hE2, 1'b0, rd_val);
        counts("R5 E demoted to S", 0, 1, 0);

        // R7 snooped ownership read on E invalidates, no shared
        snoop("R7 rdx on E", 2'd1, 8'h36, 1'b0, 1'b0, 8'h00);
        run_op(1'b0, 8'h36, 8'h00, 1'b0, rd_val);
        counts("R7 E invalidated", 1, 0, 0);
        chk("R7 refetch data", rd_val, 8'hD5);

        // R7 snooped ownership read on M flushes then invalidates
        snoop("R7 rdx on M", 2'd1, 8'h21, 1'b0, 1'b1, 8'hE1);
        run_op(1'b0, 8'h21, 8'h00, 1'b0, rd_val);
        counts("R7 M invalidated", 1, 0, 0);
        chk("R7 flushed data reread", rd_val, 8'hE1);

        // R8 tag mismatch snoop has no effect: line stays E
        snoop("R8 tag mismatch", 2'd0, 8'h25, 1'b0, 1'b0, 8'h00);
        run_op(1'b1, 8'h21, 8'hE3, 1'b0, rd_val);
        counts("R8 line untouched", 0, 0, 0);

        // R10 snoop and processor request on the same index in one cycle
        n_rd = 0; n_rdx = 0; n_wb = 0;
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 8'h21; shared_cfg = 1'b1;
        snp_valid = 1'b1; snp_cmd = 2'd1; snp_addr = 8'h21;
        #2;
        chk("R10 snoop flushes first", snp_flush, 1);
        chk("R10 flush data", snp_flush_data, 8'hE3);
        mem[8'h21] = snp_flush_data;
        @(negedge clk);
        snp_valid = 1'b0;
        while (!cpu_done) @(negedge clk);
        rd_val = cpu_rdata;
        cpu_req = 1'b0;
        @(negedge clk);
        counts("R10 request missed after snoop", 1, 0, 0);
        chk("R10 read data", rd_val, 8'hE3);

        // R8 Shared line answers a read without flushing; R5 stays valid
        snoop("R8 read on S", 2'd0, 8'h21, 1'b1, 1'b0, 8'h00);
        run_op(1'b0, 8'h21, 8'h00, 1'b0, rd_val);
        counts("R5 S still valid", 0, 0, 0);
        chk("R5 S data", rd_val, 8'hE3);

        // R8 snoop on an invalid line
        snoop("R8 invalid line", 2'd0, 8'h03, 1'b0, 1'b0, 8'h00);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule